// File: doc/BRIEF.md
# Debug UART Transmitter With Divisor

This block is the sending half of a two-wire debug serial port. Software programs a 16-bit divisor, picks a parity kind and turns the transmitter on. It then writes characters one at a time into a one-byte holding register. The engine copies each character into its shift register and sends it on a single line that idles high. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit.

A baud pulse fires once every `divisor` system clocks, and each bit lasts 16 such pulses. A bit therefore lasts 16 × divisor clocks. A divisor of zero stops the pulses, which freezes the line where it stands. Two flags are kept apart. One says the holding register can take another byte. The other says the line has finished all work. Software can queue the next character while the current one is still on the wire, and frames then follow each other with no idle gap.

Register map on the write/read bus (address → use): 0 = command (write: bit0 reset transmitter, bit1 enable, bit2 disable), 1 = parity select (bits 2:0), 2 = divisor (bits 15:0), 3 = holding register (bits 7:0, write), 4 = flags (read: bit0 ready, bit1 empty).

Top module: `uart_dbg_tx`

## Requirements
- R1: After the synchronous reset input, `txd` is 1, the flags read 0 (ready = 0, empty = 0), the parity select reads 3'b100 and the divisor reads 0.
- R2: Writing 1 to command bit1 turns the transmitter on. With nothing queued, the flags then read ready = 1 and empty = 1. While the transmitter is off, both flags read 0.
- R3: A frame is start (0), data bits 0 to 7 in ascending order, an optional parity bit, then stop (1). The line is 1 whenever no frame is in progress.
- R4: Every bit of a frame, the start bit included, lasts exactly 16 × divisor clock cycles for any divisor from 1 to 65535.
- R5: With a divisor of 0, a frame in progress makes no progress and `txd` holds its level.
- R6: Parity select bits 2:0 mean: 000 even (the parity bit makes the number of ones in data plus parity even), 001 odd, 010 parity bit always 0, 011 parity bit always 1, 1xx no parity bit. The value is taken when a character is copied into the shift register.
- R7: A write to the holding register clears ready. Ready returns on the next clock, once the byte has moved to the shift register, while that byte is still being sent. Empty stays 0 until the stop bit of the last frame has ended.
- R8: A write to the holding register while ready is 0 (full, or transmitter off) is dropped and never sent.
- R9: A character queued while a frame is in progress starts with its start bit on the cycle right after the previous stop bit ends, with no idle time.
- R10: Command bit0 cancels the frame in progress, drives `txd` to 1 on the next clock, discards any queued byte and turns the transmitter off. It takes priority over bit1 and bit2 in the same write.
- R11: Command bit2 turns the transmitter off. Ready and empty read 0, the frame already on the line finishes, and no new frame starts until bit1 is written again. Bit2 wins over bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| txd | output | 1 | Serial output line, idle high |

## Verification
The in-line properties assume the bus writes to the holding register only when software would. They also assume the divisor changes only between frames, so the baud counter is never left above a freshly lowered limit for more than one cycle. The stimulus follows both rules. Divisor and parity select are written only while the flags report empty. The one mid-frame divisor change is the write of zero in the frozen-line case, and a transmitter reset ends that case. Random characters use random parity kinds and divisors from 1 to 3. Directed cases cover back-to-back frames, a dropped write during a full holding register, the frozen line, reset during a frame and disable during a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W_DEF = 8;
    localparam int DIV_W_DEF  = 16;
    localparam int OVS_DEF    = 16;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PAR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd2;
    localparam logic [ADDR_W-1:0] A_HOLD = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

    localparam logic [2:0] PAR_RESET = 3'b100;

    typedef enum logic [1:0] {
        PK_EVEN  = 2'd0,
        PK_ODD   = 2'd1,
        PK_ZERO  = 2'd2,
        PK_ONE   = 2'd3
    } par_kind_e;

    typedef struct packed {
        logic dis;
        logic en;
        logic rst;
    } tx_cmd_t;

    typedef struct packed {
        logic empty;
        logic ready;
    } tx_status_t;

    function automatic logic parity_on(input logic [2:0] sel);
        return ~sel[2];
    endfunction

    function automatic logic parity_bit(input logic [2:0] sel, input logic data_xor);
        par_kind_e k;
        k = par_kind_e'(sel[1:0]);
        case (k)
            PK_EVEN: return data_xor;
            PK_ODD:  return ~data_xor;
            PK_ZERO: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_comb begin
        tick = run && (divisor != '0) && (cnt_q >= divisor - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || divisor == '0) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

    // R5
    stopped_count_chk: assert property (@(posedge clk) disable iff (rst)
        (divisor == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  tx_cmd_t           cmd,
    input  logic              hold_we,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic [2:0]        par_sel,
    input  logic              tick,
    output logic              busy,
    output logic              txd,
    output tx_status_t        status
);

    localparam int SH_W  = DATA_W + 2;
    localparam int CNT_W = $clog2(SH_W + 1);
    localparam int OS_W  = $clog2(OVS);

    logic              enabled_q;
    logic              hold_full_q;
    logic [DATA_W-1:0] hold_q;
    logic              busy_q;
    logic              txd_q;
    logic [SH_W-1:0]   sh_q;
    logic [CNT_W-1:0]  left_q;
    logic [OS_W-1:0]   os_q;

    logic ready, empty, accept, bit_end, frame_end, start, pbit;

    always_comb begin
        ready     = enabled_q && !hold_full_q;
        empty     = ready && !busy_q;
        accept    = hold_we && ready;
        bit_end   = busy_q && tick && (os_q == OS_W'(OVS - 1));
        frame_end = bit_end && (left_q == '0);
        start     = enabled_q && hold_full_q && (!busy_q || frame_end);
        pbit      = parity_on(par_sel) ? parity_bit(par_sel, ^hold_q) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.rst) begin
            enabled_q   <= 1'b0;
            hold_full_q <= 1'b0;
            busy_q      <= 1'b0;
            txd_q       <= 1'b1;
            sh_q        <= '1;
            left_q      <= '0;
            os_q        <= '0;
            if (rst) hold_q <= '0;
        end else begin
            if (cmd.dis)     enabled_q <= 1'b0;
            else if (cmd.en) enabled_q <= 1'b1;

            if (start)  hold_full_q <= 1'b0;
            if (accept) begin
                hold_full_q <= 1'b1;
                hold_q      <= hold_wdata;
            end

            if (start) begin
                os_q <= '0;
            end else if (busy_q && tick) begin
                os_q <= (os_q == OS_W'(OVS - 1)) ? '0 : os_q + 1'b1;
            end

            if (start) begin
                busy_q <= 1'b1;
                txd_q  <= 1'b0;
                sh_q   <= {1'b1, pbit, hold_q};
                left_q <= parity_on(par_sel) ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
            end else if (frame_end) begin
                busy_q <= 1'b0;
                txd_q  <= 1'b1;
            end else if (bit_end) begin
                txd_q  <= sh_q[0];
                sh_q   <= {1'b1, sh_q[SH_W-1:1]};
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign busy         = busy_q;
    assign txd          = txd_q;
    assign status.ready = ready;
    assign status.empty = empty;

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> txd_q);

    // R7
    empty_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        status.empty |-> status.ready);

    // R8
    dropped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_we && !status.ready) |=> $stable(hold_q));

    // R5
    frozen_line_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick && !cmd.rst) |=> $stable(txd_q));

    // R9
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && enabled_q && hold_full_q && !cmd.rst) |=> (busy_q && !txd_q));

    // R10
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.rst |=> (txd_q && !busy_q && !status.ready && !status.empty));

endmodule

// File: rtl/uart_dbg_tx.sv
module uart_dbg_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int DIV_W  = DIV_W_DEF,
    parameter int OVS    = OVS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DIV_W-1:0]  bus_wdata,
    output logic [DIV_W-1:0]  bus_rdata,
    output logic              txd
);

    logic [2:0]       par_q;
    logic [DIV_W-1:0] div_q;
    tx_cmd_t          cmd;
    tx_status_t       st;
    logic             hold_we, busy, tick;

    always_comb begin
        cmd.rst = bus_wr && (bus_addr == A_CMD) && bus_wdata[0];
        cmd.en  = bus_wr && (bus_addr == A_CMD) && bus_wdata[1];
        cmd.dis = bus_wr && (bus_addr == A_CMD) && bus_wdata[2];
        hold_we = bus_wr && (bus_addr == A_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= PAR_RESET;
            div_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_PAR) par_q <= bus_wdata[2:0];
            if (bus_addr == A_DIV) div_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PAR:   bus_rdata[2:0] = par_q;
            A_DIV:   bus_rdata      = div_q;
            A_FLAG:  bus_rdata[1:0] = st;
            default: bus_rdata      = '0;
        endcase
    end

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .divisor (div_q),
        .tick    (tick)
    );

    uart_tx_engine #(.DATA_W(DATA_W), .OVS(OVS)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .hold_we    (hold_we),
        .hold_wdata (bus_wdata[DATA_W-1:0]),
        .par_sel    (par_q),
        .tick       (tick),
        .busy       (busy),
        .txd        (txd),
        .status     (st)
    );

    // R6
    par_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == A_PAR) |=> $stable(par_q));

endmodule

// File: tb/tb_uart_dbg_tx.sv
module tb_uart_dbg_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd4;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        txd;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    uart_dbg_tx dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .txd       (txd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [2:0] sel);
        return sel[2] ? 10 : 11;
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input logic [2:0] sel, input int k);
        if (k == 0) return 1'b0;
        if (k <= 8) return d[k-1];
        if (k == 9 && !sel[2]) begin
            case (sel[1:0])
                2'd0: return ^d;
                2'd1: return ~^d;
                2'd2: return 1'b0;
                default: return 1'b1;
            endcase
        end
        return 1'b1;
    endfunction

    // called at a negedge, returns at the negedge after the write edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd4;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 3'd4;
        #1;
    endtask

    task automatic flags(output logic r, output logic e);
        logic [15:0] v;
        rd(3'd4, v);
        r = v[0];
        e = v[1];
    endtask

    // starts at offset 'off' cycles into the start bit; endm: 0 idle, 1 next queued, 2 disabled
    task automatic watch(input logic [7:0] d, input logic [2:0] sel, input int dv,
                         input int off, input int endm);
        logic r, e;
        int nb;
        nb = nbits(sel);
        repeat (8*dv - 1 - off) @(negedge clk);
        chk(txd == 1'b0, "R3 start bit", txd, 0);
        for (int k = 1; k < nb; k++) begin
            repeat (16*dv) @(negedge clk);
            chk(txd == exp_bit(d, sel, k), (k == 9 && !sel[2]) ? "R6 parity bit" : "R3/R4 frame bit",
                txd, exp_bit(d, sel, k));
        end
        repeat (8*dv) @(negedge clk);
        flags(r, e);
        chk(e == 1'b0 && txd == 1'b1, "R7 empty low in stop bit", {e, txd}, 1);
        @(negedge clk);
        flags(r, e);
        if (endm == 0)
            chk(e && r && txd, "R7 empty after stop", {e, r, txd}, 7);
        else if (endm == 1)
            chk(!e && r && !txd, "R9 next start without gap", {e, r, txd}, 2);
        else
            chk(!e && !r && txd, "R11 disabled end", {e, r, txd}, 1);
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] sel, input int dv);
        logic r, e;
        wr(3'd3, {8'h0, d});
        flags(r, e);
        chk(r == 1'b0, "R7 ready drops on write", r, 0);
        @(negedge clk);
        flags(r, e);
        chk(r == 1'b1 && e == 1'b0, "R7 ready back while sending", {r, e}, 2);
        watch(d, sel, dv, 0, 0);
    endtask

    initial begin
        #(20 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic r, e;
        int cnt;
        void'($urandom(32'd1234));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(txd == 1'b1, "R1 line idle", txd, 1);
        flags(r, e);
        chk(!r && !e, "R1 flags zero", {e, r}, 0);
        rd(3'd1, v);
        chk(v == 16'd4, "R1 parity select default", v, 4);
        rd(3'd2, v);
        chk(v == 16'd0, "R1 divisor default", v, 0);

        // R8 write while off is dropped
        wr(3'd3, 16'h00AA);
        // R2 enable
        wr(3'd0, 16'h0002);
        flags(r, e);
        chk(r && e, "R2 enabled flags", {e, r}, 3);
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R8 write while off not sent", txd, 1);

        // R4 divisor 1, no parity
        wr(3'd2, 16'd1);
        send(8'hA5, 3'b100, 1);

        // R4 start bit length with divisor 3
        wr(3'd2, 16'd3);
        wr(3'd3, 16'h0001);
        @(negedge clk);
        cnt = 0;
        while (txd == 1'b0 && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 48, "R4 start bit length", cnt, 48);
        repeat (16*3*10) @(negedge clk);
        flags(r, e);
        chk(e == 1'b1, "R4 frame finished", e, 1);

        // R6 each parity kind, divisor 2
        wr(3'd2, 16'd2);
        for (int p = 0; p < 4; p++) begin
            wr(3'd1, 16'(p));
            send(8'h6B, 3'(p), 2);
        end

        // R9 back to back, R8 write while full dropped
        wr(3'd2, 16'd1);
        wr(3'd1, 16'd1);
        wr(3'd3, 16'h0033);
        @(negedge clk);
        wr(3'd3, 16'h00C4);
        wr(3'd3, 16'h0077);
        flags(r, e);
        chk(r == 1'b0, "R8 ready low while queued", r, 0);
        watch(8'h33, 3'd1, 1, 2, 1);
        watch(8'hC4, 3'd1, 1, 0, 0);
        cnt = 0;
        repeat (60) begin
            @(negedge clk);
            if (txd == 1'b0) cnt++;
        end
        chk(cnt == 0, "R8 dropped byte never sent", cnt, 0);

        // R5 divisor zero freezes the line
        wr(3'd3, 16'h003C);
        @(negedge clk);
        wr(3'd2, 16'd0);
        repeat (100) @(negedge clk);
        flags(r, e);
        chk(txd == 1'b0 && !e, "R5 line frozen", {txd, e}, 0);

        // R10 reset command during a frame, with a queued byte
        wr(3'd3, 16'h0055);
        wr(3'd0, 16'h0007);
        flags(r, e);
        chk(txd && !r && !e, "R10 cancel", {txd, r, e}, 4);
        wr(3'd2, 16'd1);
        wr(3'd0, 16'h0002);
        flags(r, e);
        chk(r && e, "R10 queued byte discarded", {e, r}, 3);
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R10 no frame after re-enable", txd, 1);

        // R11 disable during a frame
        wr(3'd1, 16'd4);
        wr(3'd3, 16'h00C3);
        @(negedge clk);
        wr(3'd0, 16'h0006);
        flags(r, e);
        chk(!r && !e, "R11 flags off", {e, r}, 0);
        watch(8'hC3, 3'd4, 1, 1, 2);
        wr(3'd3, 16'h0011);
        repeat (60) @(negedge clk);
        chk(txd == 1'b1, "R11 no start while off", txd, 1);
        wr(3'd0, 16'h0002);
        flags(r, e);
        chk(r && e, "R11 re-enable", {e, r}, 3);

        // random characters
        for (int i = 0; i < 16; i++) begin
            int dv;
            logic [2:0] sel;
            logic [7:0] d;
            dv  = 1 + int'($urandom % 3);
            sel = 3'($urandom % 8);
            d   = 8'($urandom);
            wr(3'd2, 16'(dv));
            wr(3'd1, {13'd0, sel});
            send(d, sel, dv);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule